// File: doc/BRIEF.md
# Paged Memory Read With CRC

This block is the memory-read command layer of a single-wire slave. It runs once the slave has been selected. A byte-level link hands it received bytes. The block recognises two read commands, takes a two-byte start address, and answers with a CRC-8 over the three header bytes. It then streams bytes from a 272-location map (addresses 0x000 to 0x10F) through a synchronous memory read port. The address advances after each byte is sent.

The two commands differ only in where check bytes are placed in the stream. Page mode inserts a CRC at every 32-byte page end. Each page CRC covers the bytes sent since the last CRC, or since the start address for the first one. Field mode sends one CRC at the end of the map, covering every data byte sent. After the final CRC the block fills the link with all-ones bytes until the link reports a bus reset. A bus reset abandons the sequence at any point and returns the block to waiting for a command.

Top module: `pgmem_read`

## Requirements
- R1: After reset, `tx_valid_o` and `mem_rd_o` are low, and the block waits for a command byte.
- R2: Command 0xC3 (page mode) and command 0xF0 (field mode) start a sequence only when `selected_i` is high while the command byte arrives. Any other byte, or either command while unselected, is ignored and produces no transmit activity.
- R3: After the command, the next received byte is the start address low byte and the byte after it is the high byte. The first transmitted byte is the CRC of command, address low and address high. The CRC uses polynomial x^8+x^5+x^4+1, starts from 0x00, and shifts each byte in least significant bit first (reflected form, feedback constant 0x8C).
- R4: Data bytes follow the header CRC. They are read through the memory port starting at the start address, and the address increments by one after each byte is sent. The memory port is only read at addresses 0x000 to 0x10F, with one read per byte.
- R5: In page mode, the byte sent after the data byte at an address whose low five bits are 11111 is a CRC over the data sent since the previous CRC. The CRC register restarts at 0x00 after each CRC byte. Data then continues at the next page.
- R6: In field mode, no CRC is inserted at page ends. A single CRC over all data bytes is sent after the byte at 0x10F.
- R7: The byte at 0x10F ends the map in both modes and is followed by exactly one CRC. Page mode does not send an extra page CRC there.
- R8: After the final CRC, every further transmitted byte is 0xFF until a bus reset.
- R9: A start address above 0x10F returns no data. The final CRC (0x00, since no data was sent) follows the header CRC at once, then 0xFF bytes.
- R10: `abort_i` high returns the block to waiting for a command on the next clock edge, from any state, and `tx_valid_o` is low in the following cycle.
- R11: While `tx_valid_o` is high and `tx_ready_i` is low, `tx_valid_o` stays high and `tx_byte_o` is held.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| selected_i | input | 1 | Slave is in the selected state |
| abort_i | input | 1 | Bus reset seen by the link; abandons the sequence |
| rx_valid_i | input | 1 | Received byte strobe, one cycle per byte |
| rx_byte_i | input | 8 | Received byte |
| tx_valid_o | output | 1 | Byte offered to the link |
| tx_byte_o | output | 8 | Byte to transmit |
| tx_ready_i | input | 1 | Link takes the offered byte this cycle |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_addr_o | output | MEM_AW | Memory read address |
| mem_data_i | input | 8 | Read data, valid the cycle after `mem_rd_o` |

## Verification
The bench starts a page-mode read partway into a page. A design that reset the CRC only at page starts, or restarted it too early, would send a wrong first page CRC. A page-mode read through 0x10F catches a design that sends two CRCs there, or wraps to address 0x000. A field-mode read across 0x0FF/0x100 catches a stray page CRC. A start address of 0x200 catches reads outside the map and a nonzero final CRC. An abort in the middle of the address bytes, followed by a fresh command, catches a design that keeps partial header state. Link stalls during the field read check that the offered byte is held.

// File: rtl/pgmem_read_pkg.sv
package pgmem_read_pkg;
  localparam int unsigned ADDR_W = 16;
  localparam logic [7:0] CRC_FB = 8'h8C;  // reflected x^8+x^5+x^4+1
  localparam logic [7:0] IDLE_BYTE = 8'hFF;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR_LO,
    ST_ADDR_HI,
    ST_HDR,
    ST_FETCH,
    ST_WAIT,
    ST_DATA,
    ST_CRC,
    ST_TAIL
  } rd_state_e;
endpackage

// File: rtl/pgmem_crc8.sv
module pgmem_crc8
  import pgmem_read_pkg::*;
(
  input  logic [7:0] crc_i,
  input  logic [7:0] data_i,
  output logic [7:0] crc_o
);
  logic [7:0] stage [0:8];

  assign stage[0] = crc_i;

  for (genvar b = 0; b < 8; b++) begin : g_bit
    logic fb;
    assign fb = stage[b][0] ^ data_i[b];
    assign stage[b+1] = {1'b0, stage[b][7:1]} ^ (fb ? CRC_FB : 8'h00);
  end

  assign crc_o = stage[8];
endmodule

// File: rtl/pgmem_cmd_dec.sv
module pgmem_cmd_dec #(
  parameter logic [7:0] CMD_PAGE  = 8'hC3,
  parameter logic [7:0] CMD_FIELD = 8'hF0
) (
  input  logic [7:0] byte_i,
  input  logic       selected_i,
  output logic       hit_o,
  output logic       page_o
);
  logic is_page, is_field;

  assign is_page  = (byte_i == CMD_PAGE);
  assign is_field = (byte_i == CMD_FIELD);
  assign hit_o    = selected_i && (is_page || is_field);
  assign page_o   = is_page;
endmodule

// File: rtl/pgmem_addr_ctr.sv
module pgmem_addr_ctr
  import pgmem_read_pkg::*;
#(
  parameter int unsigned         PAGE_LSB = 5,
  parameter logic [ADDR_W-1:0]   MAP_LAST = 16'h010F
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_lo_i,
  input  logic              load_hi_i,
  input  logic [7:0]        byte_i,
  input  logic              incr_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              page_last_o,
  output logic              map_last_o,
  output logic              beyond_o
);
  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
    end else if (load_lo_i) begin
      addr_q[7:0] <= byte_i;
    end else if (load_hi_i) begin
      addr_q[15:8] <= byte_i;
    end else if (incr_i) begin
      addr_q <= addr_q + 1'b1;
    end
  end

  assign addr_o      = addr_q;
  assign page_last_o = &addr_q[PAGE_LSB-1:0];
  assign map_last_o  = (addr_q == MAP_LAST);
  assign beyond_o    = (addr_q > MAP_LAST);
endmodule

// File: rtl/pgmem_read.sv
module pgmem_read
  import pgmem_read_pkg::*;
#(
  parameter int unsigned       PAGE_BYTES = 32,
  parameter logic [ADDR_W-1:0] MAP_LAST   = 16'h010F,
  parameter logic [7:0]        CMD_PAGE   = 8'hC3,
  parameter logic [7:0]        CMD_FIELD  = 8'hF0,
  parameter int unsigned       MEM_AW     = $clog2(MAP_LAST + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              selected_i,
  input  logic              abort_i,
  input  logic              rx_valid_i,
  input  logic [7:0]        rx_byte_i,
  output logic              tx_valid_o,
  output logic [7:0]        tx_byte_o,
  input  logic              tx_ready_i,
  output logic              mem_rd_o,
  output logic [MEM_AW-1:0] mem_addr_o,
  input  logic [7:0]        mem_data_i
);
  localparam int unsigned PAGE_LSB = $clog2(PAGE_BYTES);

  rd_state_e         state_q, state_d;
  logic              page_q, page_d;
  logic              final_q, final_d;
  logic [7:0]        crc_q, crc_d;
  logic [7:0]        data_q, data_d;

  logic              cmd_hit, cmd_page;
  logic              load_lo, load_hi, incr;
  logic [ADDR_W-1:0] addr;
  logic              page_last, map_last, beyond;
  logic [7:0]        crc_din, crc_next;
  logic              rx_phase;
  logic              tx_take;

  pgmem_cmd_dec #(
    .CMD_PAGE (CMD_PAGE),
    .CMD_FIELD(CMD_FIELD)
  ) u_dec (
    .byte_i    (rx_byte_i),
    .selected_i(selected_i),
    .hit_o     (cmd_hit),
    .page_o    (cmd_page)
  );

  pgmem_addr_ctr #(
    .PAGE_LSB(PAGE_LSB),
    .MAP_LAST(MAP_LAST)
  ) u_addr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_lo_i  (load_lo),
    .load_hi_i  (load_hi),
    .byte_i     (rx_byte_i),
    .incr_i     (incr),
    .addr_o     (addr),
    .page_last_o(page_last),
    .map_last_o (map_last),
    .beyond_o   (beyond)
  );

  // header bytes come from the link, data bytes from the fetch register
  assign rx_phase = (state_q == ST_IDLE) || (state_q == ST_ADDR_LO) ||
                    (state_q == ST_ADDR_HI);
  assign crc_din  = rx_phase ? rx_byte_i : data_q;

  pgmem_crc8 u_crc (
    .crc_i (crc_q),
    .data_i(crc_din),
    .crc_o (crc_next)
  );

  assign tx_take = tx_valid_o && tx_ready_i;

  always_comb begin
    state_d = state_q;
    page_d  = page_q;
    final_d = final_q;
    crc_d   = crc_q;
    data_d  = data_q;
    load_lo = 1'b0;
    load_hi = 1'b0;
    incr    = 1'b0;
    unique case (state_q)
      ST_IDLE: if (rx_valid_i && cmd_hit) begin
        crc_d   = crc_next;
        page_d  = cmd_page;
        final_d = 1'b0;
        state_d = ST_ADDR_LO;
      end
      ST_ADDR_LO: if (rx_valid_i) begin
        crc_d   = crc_next;
        load_lo = 1'b1;
        state_d = ST_ADDR_HI;
      end
      ST_ADDR_HI: if (rx_valid_i) begin
        crc_d   = crc_next;
        load_hi = 1'b1;
        state_d = ST_HDR;
      end
      ST_HDR: if (tx_take) begin
        crc_d   = 8'h00;
        state_d = ST_FETCH;
      end
      ST_FETCH: begin
        if (beyond) begin
          final_d = 1'b1;
          state_d = ST_CRC;
        end else begin
          state_d = ST_WAIT;
        end
      end
      ST_WAIT: begin
        data_d  = mem_data_i;
        state_d = ST_DATA;
      end
      ST_DATA: if (tx_take) begin
        crc_d = crc_next;
        incr  = 1'b1;
        if (map_last) begin
          final_d = 1'b1;
          state_d = ST_CRC;
        end else if (page_q && page_last) begin
          state_d = ST_CRC;
        end else begin
          state_d = ST_FETCH;
        end
      end
      ST_CRC: if (tx_take) begin
        crc_d   = 8'h00;
        state_d = final_q ? ST_TAIL : ST_FETCH;
      end
      ST_TAIL: ;
      default: state_d = ST_IDLE;
    endcase
    if (abort_i) begin
      state_d = ST_IDLE;
      crc_d   = 8'h00;
      final_d = 1'b0;
      load_lo = 1'b0;
      load_hi = 1'b0;
      incr    = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      page_q  <= 1'b0;
      final_q <= 1'b0;
      crc_q   <= 8'h00;
      data_q  <= 8'h00;
    end else begin
      state_q <= state_d;
      page_q  <= page_d;
      final_q <= final_d;
      crc_q   <= crc_d;
      data_q  <= data_d;
    end
  end

  always_comb begin
    tx_valid_o = 1'b1;
    unique case (state_q)
      ST_HDR, ST_CRC: tx_byte_o = crc_q;
      ST_DATA:        tx_byte_o = data_q;
      ST_TAIL:        tx_byte_o = IDLE_BYTE;
      default: begin
        tx_valid_o = 1'b0;
        tx_byte_o  = 8'h00;
      end
    endcase
  end

  assign mem_rd_o   = (state_q == ST_FETCH) && !beyond && !abort_i;
  assign mem_addr_o = addr[MEM_AW-1:0];
endmodule

// File: rtl/pgmem_read_chk.sv
module pgmem_read_chk #(
  parameter int unsigned MEM_AW   = 9,
  parameter logic [15:0] MAP_LAST = 16'h010F
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              abort_i,
  input logic              tx_valid_o,
  input logic              tx_ready_i,
  input logic [7:0]        tx_byte_o,
  input logic              mem_rd_o,
  input logic [MEM_AW-1:0] mem_addr_o
);
  localparam logic [MEM_AW-1:0] LAST_M = MAP_LAST[MEM_AW-1:0];

  a_r11_hold_offer: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && !tx_ready_i && !abort_i) |=> (tx_valid_o && $stable(tx_byte_o)));

  a_r10_abort_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_i |=> !tx_valid_o);

  a_r4_read_in_map: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_o |-> (mem_addr_o <= LAST_M));

  a_r4_one_read_per_byte: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_o |=> !mem_rd_o);
endmodule

bind pgmem_read pgmem_read_chk #(
  .MEM_AW  (MEM_AW),
  .MAP_LAST(MAP_LAST)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .abort_i   (abort_i),
  .tx_valid_o(tx_valid_o),
  .tx_ready_i(tx_ready_i),
  .tx_byte_o (tx_byte_o),
  .mem_rd_o  (mem_rd_o),
  .mem_addr_o(mem_addr_o)
);

// File: tb/pgmem_read_tb.sv
`timescale 1ns/1ps
module pgmem_read_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       selected_i = 1'b0;
  logic       abort_i = 1'b0;
  logic       rx_valid_i = 1'b0;
  logic [7:0] rx_byte_i = 8'h00;
  logic       tx_valid_o;
  logic [7:0] tx_byte_o;
  logic       tx_ready_i = 1'b0;
  logic       mem_rd_o;
  logic [8:0] mem_addr_o;
  logic [7:0] mem_data_i = 8'h00;

  int n_chk = 0;
  int n_fail = 0;
  int cycles = 0;

  always #2 clk_i = ~clk_i;

  pgmem_read u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .selected_i(selected_i), .abort_i(abort_i),
    .rx_valid_i(rx_valid_i), .rx_byte_i(rx_byte_i),
    .tx_valid_o(tx_valid_o), .tx_byte_o(tx_byte_o), .tx_ready_i(tx_ready_i),
    .mem_rd_o(mem_rd_o), .mem_addr_o(mem_addr_o), .mem_data_i(mem_data_i)
  );

  function automatic logic [7:0] mem_val(input logic [8:0] a);
    logic [7:0] v;
    v = a[7:0] * 8'd37 + 8'd11;
    return a[8] ? (v ^ 8'hA5) : v;
  endfunction

  always @(posedge clk_i) if (mem_rd_o) mem_data_i <= mem_val(mem_addr_o);

  function automatic logic [7:0] crc_b(input logic [7:0] c, input logic [7:0] d);
    logic [7:0] r;
    r = c;
    for (int i = 0; i < 8; i++) begin
      if (r[0] ^ d[i]) r = (r >> 1) ^ 8'h8C;
      else r = r >> 1;
    end
    return r;
  endfunction

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  always @(posedge clk_i) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: act=%0d exp<=100000 cycles", cycles);
      summary();
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic send_rx(input logic [7:0] b);
    @(negedge clk_i);
    rx_valid_i = 1'b1;
    rx_byte_i  = b;
    @(negedge clk_i);
    rx_valid_i = 1'b0;
  endtask

  task automatic do_abort();
    @(negedge clk_i);
    abort_i = 1'b1;
    @(negedge clk_i);
    abort_i = 1'b0;
  endtask

  // wait for an offered byte, optionally stall, then take it
  task automatic get_byte(input int stall, input string req, output logic [7:0] b);
    int w = 0;
    @(negedge clk_i);
    while (!tx_valid_o && w < 300) begin
      @(negedge clk_i);
      w++;
    end
    if (!tx_valid_o) chk(1'b0, {req, " timeout"}, 0, 1);
    b = tx_byte_o;
    for (int i = 0; i < stall; i++) begin
      @(negedge clk_i);
      chk(tx_valid_o && tx_byte_o == b, "R11 hold", tx_byte_o, b);
    end
    tx_ready_i = 1'b1;
    @(negedge clk_i);
    tx_ready_i = 1'b0;
  endtask

  task automatic expect_byte(input int stall, input string req, input logic [7:0] exp);
    logic [7:0] b;
    get_byte(stall, req, b);
    chk(b == exp, req, b, exp);
  endtask

  task automatic start_cmd(input logic [7:0] cmd, input logic [15:0] a);
    logic [7:0] c;
    send_rx(cmd);
    send_rx(a[7:0]);
    send_rx(a[15:8]);
    c = crc_b(crc_b(crc_b(8'h00, cmd), a[7:0]), a[15:8]);
    expect_byte(0, "R3 header crc", c);
  endtask

  task automatic t_reset();
    chk(tx_valid_o == 1'b0, "R1 tx_valid", tx_valid_o, 0);
    chk(mem_rd_o == 1'b0, "R1 mem_rd", mem_rd_o, 0);
  endtask

  task automatic t_ignored();
    bit seen = 0;
    do_abort();
    selected_i = 1'b0;
    send_rx(8'hC3); send_rx(8'h01); send_rx(8'h00);
    selected_i = 1'b1;
    send_rx(8'h33); send_rx(8'h02); send_rx(8'h00);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk_i);
      if (tx_valid_o) seen = 1;
    end
    chk(!seen, "R2 ignored commands", seen, 0);
  endtask

  task automatic t_page_mid();
    logic [7:0] c = 8'h00;
    do_abort();
    start_cmd(8'hC3, 16'h001C);
    for (int a = 'h1C; a <= 'h1F; a++) begin
      expect_byte(0, "R4 page data", mem_val(9'(a)));
      c = crc_b(c, mem_val(9'(a)));
    end
    expect_byte(0, "R5 first page crc", c);
    c = 8'h00;
    for (int a = 'h20; a <= 'h3F; a++) begin
      expect_byte(0, "R5 page data", mem_val(9'(a)));
      c = crc_b(c, mem_val(9'(a)));
    end
    expect_byte(0, "R5 full page crc", c);
    do_abort();
    chk(tx_valid_o == 1'b0, "R10 abort", tx_valid_o, 0);
  endtask

  task automatic t_page_end();
    logic [7:0] c = 8'h00;
    do_abort();
    start_cmd(8'hC3, 16'h00F8);
    for (int a = 'hF8; a <= 'hFF; a++) begin
      expect_byte(0, "R4 data", mem_val(9'(a)));
      c = crc_b(c, mem_val(9'(a)));
    end
    expect_byte(0, "R5 page crc", c);
    c = 8'h00;
    for (int a = 'h100; a <= 'h10F; a++) begin
      expect_byte(0, "R4 upper data", mem_val(9'(a)));
      c = crc_b(c, mem_val(9'(a)));
    end
    expect_byte(0, "R7 single final crc", c);
    expect_byte(0, "R8 idle ones", 8'hFF);
    expect_byte(0, "R8 idle ones", 8'hFF);
  endtask

  task automatic t_field();
    logic [7:0] c = 8'h00;
    do_abort();
    start_cmd(8'hF0, 16'h00FE);
    for (int a = 'hFE; a <= 'h10F; a++) begin
      expect_byte((a % 5 == 0) ? 2 : 0, "R6 field data", mem_val(9'(a)));
      c = crc_b(c, mem_val(9'(a)));
    end
    expect_byte(3, "R6 field crc", c);
    expect_byte(1, "R8 idle ones", 8'hFF);
  endtask

  task automatic t_beyond();
    do_abort();
    send_rx(8'hC3);
    send_rx(8'h10);
    do_abort();
    // R10: a stale header would take 0xC3 as the high address byte
    start_cmd(8'hC3, 16'h0200);
    expect_byte(0, "R9 final crc at once", 8'h00);
    expect_byte(0, "R9 idle ones", 8'hFF);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_ignored();
    t_page_mid();
    t_page_end();
    t_field();
    t_beyond();
    summary();
  end
endmodule